// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the main control state machine of a multicycle processor whose datapath is one byte wide. Each 32-bit instruction arrives from memory one byte per cycle. Four fetch states therefore load the instruction register one byte at a time, starting with the most significant byte, and each of them also advances the program counter. A shared decode state follows, and then a short, class-specific tail that steers the ALU, the memory and the register file.

The block has three inputs: the clock, a synchronous reset and the opcode field of the instruction register. On every cycle it drives the full control vector: program-counter write strobes and source select, address select, memory strobes, the instruction-register byte enables, register write controls, and the ALU operand and operation-class selects. Five instruction classes are supported: load byte, store byte, register-register, branch-if-equal and jump. Any other opcode returns to fetch straight after decode.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` (active high, synchronous) is sampled high at a clock edge, the block enters the first fetch state and then shows the first-fetch control vector.
- R2: Fetch runs through four consecutive states that enable `ir_byte_en` = 4'b1000, 4'b0100, 4'b0010 and 4'b0001, in that order. Each of these states also asserts `mem_rd` and `pc_wr`, with `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=2'b01, `alu_op`=2'b00 and `pc_src`=2'b00.
- R3: The state after the last fetch is decode. It drives `alu_a_sel`=0, `alu_b_sel`=2'b11 and `alu_op`=2'b00.
- R4: For load byte (default opcode 6'b100000), decode is followed by three states. The address state drives `alu_a_sel`=1, `alu_b_sel`=2'b10 and `alu_op`=2'b00. The read state drives `mem_rd` with `addr_sel`=1. The write-back state drives `reg_wr` with `wb_sel`=1 and `dst_sel`=0. Counting the starting fetch state as cycle 1, the first fetch state recurs at cycle 9.
- R5: For store byte (default 6'b101000), decode is followed by the same address state and then a write state that drives `mem_wr` with `addr_sel`=1. The first fetch state recurs at cycle 8.
- R6: For register-register (default 6'b000000), decode is followed by an execute state and a completion state. Execute drives `alu_a_sel`=1, `alu_b_sel`=2'b00 and `alu_op`=2'b10. Completion drives `reg_wr` with `dst_sel`=1 and `wb_sel`=0. The first fetch state recurs at cycle 8.
- R7: For branch-if-equal (default 6'b000100), decode is followed by one state that drives `pc_wr_cond` with `pc_src`=2'b01, `alu_a_sel`=1, `alu_b_sel`=2'b00 and `alu_op`=2'b01. The first fetch state recurs at cycle 7.
- R8: For jump (default 6'b000010), decode is followed by one state that drives `pc_wr` with `pc_src`=2'b10. The first fetch state recurs at cycle 7.
- R9: Every final state (store write, load write-back, register-register completion, branch, jump) is followed on the next clock by the first fetch state.
- R10: An opcode matching no class makes decode return directly to the first fetch state at cycle 6. No `reg_wr`, `mem_wr` or `pc_wr_cond` is asserted along the way.
- R11: In every state, a strobe that the requirements above do not name for that state is 0, and so is every select field they do not name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write when the ALU reports equality |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU register, 10 jump target |
| addr_sel | output | 1 | Memory address: 0 program counter, 1 ALU register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_byte_en | output | 4 | Instruction-register byte load enables, bit 3 = byte 3 |
| dst_sel | output | 1 | Destination register: 0 rt field, 1 rd field |
| reg_wr | output | 1 | Register file write strobe |
| wb_sel | output | 1 | Write-back data: 0 ALU register, 1 memory data register |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 one, 10 offset, 11 scaled offset |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |

## Verification
Each of the five instruction classes is run through its own full sequence, and the complete control vector is compared in every cycle. This separates the shared fetch and decode prefix from the class tails, and it pins the cycle on which fetch recurs. Load byte and store byte share the address state and differ only in the state after it, so running them back to back shows that the opcode is looked at a second time. An unknown opcode shows that decode has a fallback. A reset raised in the middle of an instruction shows that the return to the first fetch state is synchronous and happens from any state.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int IR_BYTES = 4;

  typedef enum logic [3:0] {
    ST_FETCH3 = 4'd0,
    ST_FETCH2 = 4'd1,
    ST_FETCH1 = 4'd2,
    ST_FETCH0 = 4'd3,
    ST_DECODE = 4'd4,
    ST_ADDR   = 4'd5,
    ST_RDMEM  = 4'd6,
    ST_LDBACK = 4'd7,
    ST_WRMEM  = 4'd8,
    ST_EXEC   = 4'd9,
    ST_RDONE  = 4'd10,
    ST_BRANCH = 4'd11,
    ST_JUMP   = 4'd12
  } step_e;

  typedef struct packed {
    logic                pc_wr;
    logic                pc_wr_cond;
    logic [1:0]          pc_src;
    logic                addr_sel;
    logic                mem_rd;
    logic                mem_wr;
    logic [IR_BYTES-1:0] ir_en;
    logic                dst_sel;
    logic                reg_wr;
    logic                wb_sel;
    logic                a_sel;
    logic [1:0]          b_sel;
    logic [1:0]          op;
  } ctl_t;

  // Byte slot loaded by a fetch state; -1 for non-fetch states.
  function automatic int fetch_slot(step_e s);
    case (s)
      ST_FETCH3: fetch_slot = 3;
      ST_FETCH2: fetch_slot = 2;
      ST_FETCH1: fetch_slot = 1;
      ST_FETCH0: fetch_slot = 0;
      default:   fetch_slot = -1;
    endcase
  endfunction

  function automatic logic is_final(step_e s);
    is_final = (s == ST_WRMEM) || (s == ST_LDBACK) || (s == ST_RDONE) ||
               (s == ST_BRANCH) || (s == ST_JUMP);
  endfunction

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int                OPW   = 6,
  parameter logic [OPW-1:0]    OP_RR = 6'b000000,
  parameter logic [OPW-1:0]    OP_LB = 6'b100000,
  parameter logic [OPW-1:0]    OP_SB = 6'b101000,
  parameter logic [OPW-1:0]    OP_BE = 6'b000100,
  parameter logic [OPW-1:0]    OP_JP = 6'b000010
) (
  input  step_e          cur,
  input  logic [OPW-1:0] opc,
  output step_e          nxt
);

  always_comb begin
    case (cur)
      ST_FETCH3: nxt = ST_FETCH2;
      ST_FETCH2: nxt = ST_FETCH1;
      ST_FETCH1: nxt = ST_FETCH0;
      ST_FETCH0: nxt = ST_DECODE;
      ST_DECODE: begin
        if (opc == OP_LB || opc == OP_SB) nxt = ST_ADDR;
        else if (opc == OP_RR)            nxt = ST_EXEC;
        else if (opc == OP_BE)            nxt = ST_BRANCH;
        else if (opc == OP_JP)            nxt = ST_JUMP;
        else                              nxt = ST_FETCH3;
      end
      ST_ADDR: begin
        if (opc == OP_LB)      nxt = ST_RDMEM;
        else if (opc == OP_SB) nxt = ST_WRMEM;
        else                   nxt = ST_FETCH3;
      end
      ST_RDMEM: nxt = ST_LDBACK;
      ST_EXEC:  nxt = ST_RDONE;
      default:  nxt = ST_FETCH3;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  step_e cur,
  output ctl_t  ctl
);

  logic [IR_BYTES-1:0] byte_en;

  generate
    for (genvar b = 0; b < IR_BYTES; b++) begin : g_ben
      assign byte_en[b] = (fetch_slot(cur) == b);
    end
  endgenerate

  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH3, ST_FETCH2, ST_FETCH1, ST_FETCH0: begin
        ctl.mem_rd = 1'b1;
        ctl.pc_wr  = 1'b1;
        ctl.b_sel  = 2'b01;
        ctl.ir_en  = byte_en;
      end
      ST_DECODE: ctl.b_sel = 2'b11;
      ST_ADDR: begin
        ctl.a_sel = 1'b1;
        ctl.b_sel = 2'b10;
      end
      ST_RDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDBACK: begin
        ctl.reg_wr = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      ST_WRMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctl.a_sel = 1'b1;
        ctl.op    = 2'b10;
      end
      ST_RDONE: begin
        ctl.reg_wr  = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctl.a_sel      = 1'b1;
        ctl.op         = 2'b01;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = 2'b10;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_state.sv
module mc_ctrl_state
  import mc_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_e nxt,
  output step_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_FETCH3;
    else     cur <= nxt;
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int             OPW   = 6,
  parameter logic [OPW-1:0] OP_RR = 6'b000000,
  parameter logic [OPW-1:0] OP_LB = 6'b100000,
  parameter logic [OPW-1:0] OP_SB = 6'b101000,
  parameter logic [OPW-1:0] OP_BE = 6'b000100,
  parameter logic [OPW-1:0] OP_JP = 6'b000010
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic           pc_wr,
  output logic           pc_wr_cond,
  output logic [1:0]     pc_src,
  output logic           addr_sel,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [3:0]     ir_byte_en,
  output logic           dst_sel,
  output logic           reg_wr,
  output logic           wb_sel,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_op
);

  step_e cur_st;
  step_e nxt_st;
  ctl_t  ctl;

  mc_ctrl_state u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_st),
    .cur (cur_st)
  );

  mc_ctrl_next #(
    .OPW(OPW), .OP_RR(OP_RR), .OP_LB(OP_LB), .OP_SB(OP_SB),
    .OP_BE(OP_BE), .OP_JP(OP_JP)
  ) u_next (
    .cur (cur_st),
    .opc (opcode),
    .nxt (nxt_st)
  );

  mc_ctrl_out u_out (
    .cur (cur_st),
    .ctl (ctl)
  );

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign pc_src     = ctl.pc_src;
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_byte_en = ctl.ir_en;
  assign dst_sel    = ctl.dst_sel;
  assign reg_wr     = ctl.reg_wr;
  assign wb_sel     = ctl.wb_sel;
  assign alu_a_sel  = ctl.a_sel;
  assign alu_b_sel  = ctl.b_sel;
  assign alu_op     = ctl.op;

  // Named events for the assertions
  logic in_fetch;
  logic at_final;
  logic at_decode;
  logic op_known;
  assign in_fetch  = (ir_byte_en != 4'b0000);
  assign at_final  = is_final(cur_st);
  assign at_decode = (cur_st == ST_DECODE);
  assign op_known  = (opcode == OP_RR) || (opcode == OP_LB) || (opcode == OP_SB) ||
                     (opcode == OP_BE) || (opcode == OP_JP);

  assert_reset_fetch_R1: assert property (@(posedge clk)
    $past(rst) |-> (cur_st == ST_FETCH3));

  assert_fetch_order_R2: assert property (@(posedge clk) disable iff (rst)
    (ir_byte_en == 4'b1000) |=> (ir_byte_en == 4'b0100));

  assert_fetch_single_R2: assert property (@(posedge clk) disable iff (rst)
    in_fetch |-> ($onehot0(ir_byte_en) && mem_rd && pc_wr && !addr_sel));

  assert_fetch_to_decode_R3: assert property (@(posedge clk) disable iff (rst)
    (ir_byte_en == 4'b0001) |=> at_decode);

  assert_final_return_R9: assert property (@(posedge clk) disable iff (rst)
    at_final |=> (ir_byte_en == 4'b1000));

  assert_unknown_op_R10: assert property (@(posedge clk) disable iff (rst)
    (at_decode && !op_known) |=> (ir_byte_en == 4'b1000));

  assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr) && !(pc_wr && pc_wr_cond));

endmodule

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, dst_sel, reg_wr, wb_sel, alu_a_sel;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  logic [3:0] ir_byte_en;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5ns clk = ~clk;

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_byte_en(ir_byte_en), .dst_sel(dst_sel), .reg_wr(reg_wr),
    .wb_sel(wb_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op)
  );

  // Observed vector: pc_wr pc_wr_cond pc_src(2) addr_sel mem_rd mem_wr ir(4) dst reg_wr wb a b(2) op(2)
  function automatic logic [19:0] obs();
    return {pc_wr, pc_wr_cond, pc_src, addr_sel, mem_rd, mem_wr, ir_byte_en,
            dst_sel, reg_wr, wb_sel, alu_a_sel, alu_b_sel, alu_op};
  endfunction

  localparam logic [19:0] V_F3  = 20'b1_0_00_0_1_0_1000_0_0_0_0_01_00;
  localparam logic [19:0] V_F2  = 20'b1_0_00_0_1_0_0100_0_0_0_0_01_00;
  localparam logic [19:0] V_F1  = 20'b1_0_00_0_1_0_0010_0_0_0_0_01_00;
  localparam logic [19:0] V_F0  = 20'b1_0_00_0_1_0_0001_0_0_0_0_01_00;
  localparam logic [19:0] V_DEC = 20'b0_0_00_0_0_0_0000_0_0_0_0_11_00;
  localparam logic [19:0] V_ADR = 20'b0_0_00_0_0_0_0000_0_0_0_1_10_00;
  localparam logic [19:0] V_MRD = 20'b0_0_00_1_1_0_0000_0_0_0_0_00_00;
  localparam logic [19:0] V_LWB = 20'b0_0_00_0_0_0_0000_0_1_1_0_00_00;
  localparam logic [19:0] V_MWR = 20'b0_0_00_1_0_1_0000_0_0_0_0_00_00;
  localparam logic [19:0] V_REX = 20'b0_0_00_0_0_0_0000_0_0_0_1_00_10;
  localparam logic [19:0] V_RDN = 20'b0_0_00_0_0_0_0000_1_1_0_0_00_00;
  localparam logic [19:0] V_BR  = 20'b0_1_01_0_0_0_0000_0_0_0_1_00_01;
  localparam logic [19:0] V_JP  = 20'b1_0_10_0_0_0_0000_0_0_0_0_00_00;

  typedef struct packed {
    logic [5:0]            op;
    logic [3:0]            len;
    logic [0:8][19:0]      seq;
    logic [8*3-1:0]        tag;
  } row_t;

  localparam row_t TAB [6] = '{
    '{6'b100000, 4'd9, {V_F3, V_F2, V_F1, V_F0, V_DEC, V_ADR, V_MRD, V_LWB, V_F3}, "R4 "},
    '{6'b101000, 4'd8, {V_F3, V_F2, V_F1, V_F0, V_DEC, V_ADR, V_MWR, V_F3, V_F3}, "R5 "},
    '{6'b000000, 4'd8, {V_F3, V_F2, V_F1, V_F0, V_DEC, V_REX, V_RDN, V_F3, V_F3}, "R6 "},
    '{6'b000100, 4'd7, {V_F3, V_F2, V_F1, V_F0, V_DEC, V_BR,  V_F3, V_F3, V_F3}, "R7 "},
    '{6'b000010, 4'd7, {V_F3, V_F2, V_F1, V_F0, V_DEC, V_JP,  V_F3, V_F3, V_F3}, "R8 "},
    '{6'b111111, 4'd6, {V_F3, V_F2, V_F1, V_F0, V_DEC, V_F3,  V_F3, V_F3, V_F3}, "R10"}
  };

  task automatic check(input logic [19:0] exp, input string req, input int cyc);
    logic [19:0] got;
    got = obs();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %b expected %b", req, cyc, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200us;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(V_F3, "R1", 0);
    rst = 1'b0;

    // Table walk, R2 R3 R9 R11 covered by every row's full vectors
    for (int pass = 0; pass < 2; pass++) begin
      for (int r = 0; r < 6; r++) begin
        opcode = TAB[r].op;
        for (int i = 0; i < int'(TAB[r].len); i++) begin
          check(TAB[r].seq[i], string'(TAB[r].tag), i + 1);
          if (i < int'(TAB[r].len) - 1) @(negedge clk);
        end
      end
    end

    // R5 then R4 back to back: second opcode look in the address state
    opcode = 6'b101000;
    repeat (5) @(negedge clk);
    check(V_ADR, "R5", 6);
    @(negedge clk);
    check(V_MWR, "R5", 7);
    @(negedge clk);
    check(V_F3, "R9", 8);

    // R1: synchronous reset in the middle of a load
    opcode = 6'b100000;
    repeat (6) @(negedge clk);
    check(V_MRD, "R4", 7);
    rst = 1'b1;
    check(V_MRD, "R1", 7);
    @(negedge clk);
    check(V_F3, "R1", 1);
    @(negedge clk);
    check(V_F3, "R1", 1);
    rst = 1'b0;
    @(negedge clk);
    check(V_F2, "R2", 2);

    summary();
  end

endmodule